// File: doc/BRIEF.md
# Bridge Sensor Converter Readout Controller

This block is the host side of a read-only, two-wire link to a sigma-delta bridge converter. The converter pulls its single output line low when a fresh conversion is waiting. The controller sees that fall through a synchroniser, drives the serial clock and shifts in a 32-bit frame. It then splits the frame into a 20-bit conversion code, four padding bits and a status byte.

Each frame is checked before it is trusted. The status byte carries a fixed two-bit pattern, a device identity field, a ready bit, an out-of-range bit and echoes of the gain and filter selections the device is wired for. The controller compares all of these with what it expects and with its own gain and filter settings. It converts the offset-binary code to two's complement and reports it together with a frame strobe, a valid strobe and three error flags. The valid strobe is held off whenever any check fails. While the power control is low, the data line is ignored and any transfer in flight is abandoned.

Top module: `bridge_adc_reader`

## Requirements
- R1: A transfer starts only when the synchronised data line falls while `pwr_on` is high and no transfer is running; with `pwr_on` low, a low data line produces no clock pulses and no frame.
- R2: `ser_clk` rests high. A frame consists of exactly 32 low pulses, and every low phase and every high phase lasts at least `HALF_CYCLES` system clocks (10 clocks = 100 ns by default, never below 100 ns).
- R3: The data line is sampled as `ser_clk` rises, most significant bit first. Frame bits [31:12] are the code, [11:8] are padding and [7:0] are the status byte.
- R4: `result` is the code with its MSB inverted, giving two's complement. Code 0x00000 gives 0x80000, code 0x80000 gives 0x00000 and code 0xFFFFF gives 0x7FFFF.
- R5: `status` presents the received status byte. Bit 7 is the ready bit (0 = conversion available), bit 6 the filter echo (1 = slow 10 Hz filter), bit 5 the range error, bits 4:3 the identity (must be 00), bit 2 the gain echo (1 = unity gain, 0 = gain 128) and bits 1:0 the pattern (must be 01).
- R6: `flag_link` is set when the pattern is not 01, when the identity is not 00, when the ready bit is 1, or when the padding is not zero.
- R7: `flag_range` equals status bit 5 of the frame.
- R8: `flag_cfg` is set when status bit 2 differs from `cfg_gain_one` or status bit 6 differs from `cfg_filter_slow`.
- R9: `frame_seen` pulses for one cycle for every completed frame. `result_valid` pulses in the same cycle only when `flag_link`, `flag_range` and `flag_cfg` are all clear.
- R10: Dropping `pwr_on` during a transfer returns `ser_clk` high on the next clock edge, and no frame is reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pwr_on | input | 1 | Power control; low parks the link and ignores the data line |
| cfg_gain_one | input | 1 | Expected gain echo (1 = unity gain) |
| cfg_filter_slow | input | 1 | Expected filter echo (1 = slow filter) |
| adc_sdo | input | 1 | Asynchronous combined ready/data line from the converter |
| ser_clk | output | 1 | Serial clock to the converter |
| result | output | 20 | Signed conversion result |
| status | output | 8 | Received status byte |
| frame_seen | output | 1 | One-cycle strobe per completed frame |
| result_valid | output | 1 | One-cycle strobe for a frame that passed every check |
| flag_link | output | 1 | Transfer integrity failure for the last frame |
| flag_range | output | 1 | Input out of range for the last frame |
| flag_cfg | output | 1 | Gain or filter echo mismatch for the last frame |

## Verification
The assertions assume that the converter changes the data line only after a falling clock edge and holds it through the following rising edge. They also assume that `pwr_on` and the configuration inputs are synchronous to `clk`, and that frames are far enough apart that the strobes never fall in adjacent cycles. The bench's converter model drives each bit one nanosecond after the clock falls and returns the line high a few cycles after the last rising edge. It leaves idle gaps between frames and changes the configuration only between frames. This keeps every stimulus within those assumptions.

// File: rtl/bradc_pkg.sv
package bradc_pkg;
  localparam int RES_W   = 20;
  localparam int PAD_W   = 4;
  localparam int STAT_W  = 8;
  localparam int FRAME_W = RES_W + PAD_W + STAT_W;

  // status byte bit positions (fixed by the converter)
  localparam int ST_RDY  = 7;
  localparam int ST_FILT = 6;
  localparam int ST_ERR  = 5;
  localparam int ST_ID_H = 4;
  localparam int ST_ID_L = 3;
  localparam int ST_GAIN = 2;

  typedef logic [FRAME_W-1:0] frame_t;
  typedef logic [STAT_W-1:0]  status_t;
  typedef logic [RES_W-1:0]   code_t;

  function automatic code_t offset_to_signed(input code_t code);
    return {~code[RES_W-1], code[RES_W-2:0]};
  endfunction

  function automatic logic link_bad(input frame_t f);
    status_t s;
    logic [PAD_W-1:0] pad;
    s   = f[STAT_W-1:0];
    pad = f[STAT_W +: PAD_W];
    return (s[1:0] != 2'b01) || (s[ST_ID_H:ST_ID_L] != 2'b00) ||
           s[ST_RDY] || (pad != '0);
  endfunction

  function automatic logic cfg_bad(input status_t s, input logic gain_one,
                                   input logic filt_slow);
    return (s[ST_GAIN] != gain_one) || (s[ST_FILT] != filt_slow);
  endfunction
endpackage

// File: rtl/bradc_ready_sync.sv
module bradc_ready_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_on,
  input  logic line_i,
  output logic line_sync_o,
  output logic fall_o
);
  logic meta_q, sync_q, prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      meta_q <= 1'b1;
      sync_q <= 1'b1;
      prev_q <= 1'b1;
    end else begin
      meta_q <= line_i;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign line_sync_o = sync_q;
  assign fall_o      = pwr_on & prev_q & ~sync_q;
endmodule

// File: rtl/bradc_shifter.sv
module bradc_shifter
  import bradc_pkg::*;
#(
  parameter int HALF = 10
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   pwr_on,
  input  logic   start,
  input  logic   sdi,
  output logic   sclk,
  output frame_t frame,
  output logic   done
);
  localparam int HW = $clog2(HALF + 1);
  localparam int BW = $clog2(FRAME_W);
  localparam logic [HW-1:0] HLAST = HW'(HALF - 1);
  localparam logic [BW-1:0] BLAST = BW'(FRAME_W - 1);

  typedef enum logic [1:0] {S_IDLE, S_LOW, S_HIGH} state_t;
  state_t        state;
  logic [HW-1:0] hcnt;
  logic [BW-1:0] bcnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE;
      sclk  <= 1'b1;
      hcnt  <= '0;
      bcnt  <= '0;
      frame <= '0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!pwr_on) begin
        state <= S_IDLE;
        sclk  <= 1'b1;
        hcnt  <= '0;
        bcnt  <= '0;
      end else begin
        case (state)
          S_IDLE: if (start) begin
            state <= S_LOW;
            sclk  <= 1'b0;
            hcnt  <= '0;
            bcnt  <= '0;
          end
          S_LOW: if (hcnt == HLAST) begin
            sclk  <= 1'b1;
            hcnt  <= '0;
            frame <= {frame[FRAME_W-2:0], sdi};
            if (bcnt == BLAST) begin
              state <= S_IDLE;
              done  <= 1'b1;
            end else begin
              state <= S_HIGH;
            end
          end else begin
            hcnt <= hcnt + 1'b1;
          end
          S_HIGH: if (hcnt == HLAST) begin
            sclk  <= 1'b0;
            hcnt  <= '0;
            bcnt  <= bcnt + 1'b1;
            state <= S_LOW;
          end else begin
            hcnt <= hcnt + 1'b1;
          end
          default: state <= S_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/bradc_frame_check.sv
module bradc_frame_check
  import bradc_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    done,
  input  frame_t  frame,
  input  logic    cfg_gain_one,
  input  logic    cfg_filter_slow,
  output code_t   result,
  output status_t status,
  output logic    frame_seen,
  output logic    result_valid,
  output logic    flag_link,
  output logic    flag_range,
  output logic    flag_cfg
);
  status_t st_w;
  logic    link_w, range_w, cfg_w;

  assign st_w    = frame[STAT_W-1:0];
  assign link_w  = link_bad(frame);
  assign range_w = st_w[ST_ERR];
  assign cfg_w   = cfg_bad(st_w, cfg_gain_one, cfg_filter_slow);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      result       <= '0;
      status       <= '0;
      frame_seen   <= 1'b0;
      result_valid <= 1'b0;
      flag_link    <= 1'b0;
      flag_range   <= 1'b0;
      flag_cfg     <= 1'b0;
    end else begin
      frame_seen   <= done;
      result_valid <= done & ~(link_w | range_w | cfg_w);
      if (done) begin
        result     <= offset_to_signed(frame[FRAME_W-1 -: RES_W]);
        status     <= st_w;
        flag_link  <= link_w;
        flag_range <= range_w;
        flag_cfg   <= cfg_w;
      end
    end
  end
endmodule

// File: rtl/bridge_adc_reader.sv
module bridge_adc_reader
  import bradc_pkg::*;
#(
  parameter int CLK_PERIOD_NS = 10,
  parameter int HALF_CYCLES   = 10,
  parameter int MIN_PHASE_NS  = 100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwr_on,
  input  logic              cfg_gain_one,
  input  logic              cfg_filter_slow,
  input  logic              adc_sdo,
  output logic              ser_clk,
  output logic [RES_W-1:0]  result,
  output logic [STAT_W-1:0] status,
  output logic              frame_seen,
  output logic              result_valid,
  output logic              flag_link,
  output logic              flag_range,
  output logic              flag_cfg
);
  localparam int MIN_HALF = (MIN_PHASE_NS + CLK_PERIOD_NS - 1) / CLK_PERIOD_NS;
  localparam int HALF_EFF = (HALF_CYCLES < MIN_HALF) ? MIN_HALF : HALF_CYCLES;

  // named internal events, visible to the bound checker
  logic   sdo_sync_w;
  logic   rdy_fall_w;
  logic   frame_done_w;
  frame_t frame_w;

  bradc_ready_sync u_sync (
    .clk         (clk),
    .rst_n       (rst_n),
    .pwr_on      (pwr_on),
    .line_i      (adc_sdo),
    .line_sync_o (sdo_sync_w),
    .fall_o      (rdy_fall_w)
  );

  bradc_shifter #(.HALF(HALF_EFF)) u_shift (
    .clk    (clk),
    .rst_n  (rst_n),
    .pwr_on (pwr_on),
    .start  (rdy_fall_w),
    .sdi    (sdo_sync_w),
    .sclk   (ser_clk),
    .frame  (frame_w),
    .done   (frame_done_w)
  );

  bradc_frame_check u_check (
    .clk             (clk),
    .rst_n           (rst_n),
    .done            (frame_done_w),
    .frame           (frame_w),
    .cfg_gain_one    (cfg_gain_one),
    .cfg_filter_slow (cfg_filter_slow),
    .result          (result),
    .status          (status),
    .frame_seen      (frame_seen),
    .result_valid    (result_valid),
    .flag_link       (flag_link),
    .flag_range      (flag_range),
    .flag_cfg        (flag_cfg)
  );
endmodule

// File: rtl/bradc_reader_sva.sv
module bradc_reader_sva #(
  parameter int MIN_HALF   = 10,
  parameter int FRAME_BITS = 32
) (
  input logic       clk,
  input logic       rst_n,
  input logic       pwr_on,
  input logic       ser_clk,
  input logic       frame_done_w,
  input logic       frame_seen,
  input logic       result_valid,
  input logic [7:0] status,
  input logic       flag_range
);
  logic        sclk_d, en_d;
  logic [6:0]  rise_cnt;
  logic [15:0] low_cnt;
  logic        rise;

  assign rise = ser_clk & ~sclk_d;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sclk_d   <= 1'b1;
      en_d     <= 1'b0;
      rise_cnt <= '0;
      low_cnt  <= '0;
    end else begin
      sclk_d <= ser_clk;
      en_d   <= pwr_on;
      if (frame_done_w || !pwr_on) rise_cnt <= '0;
      else if (rise)               rise_cnt <= rise_cnt + 1'b1;
      if (ser_clk)                 low_cnt <= '0;
      else if (low_cnt != '1)      low_cnt <= low_cnt + 1'b1;
    end
  end

  AST_LOW_PHASE_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    (rise && en_d) |-> (int'(low_cnt) >= MIN_HALF)); // R2

  AST_FRAME_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done_w |-> ((int'(rise_cnt) + int'(rise)) == FRAME_BITS)); // R3

  AST_PARK_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_on |=> ser_clk); // R10

  AST_VALID_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid |-> (status[1:0] == 2'b01 && status[4:3] == 2'b00 &&
                      !status[7] && !flag_range)); // R6

  AST_VALID_WITH_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid |-> frame_seen); // R9

  AST_SEEN_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_seen |=> !frame_seen); // R9
endmodule

bind bridge_adc_reader bradc_reader_sva u_sva (
  .clk          (clk),
  .rst_n        (rst_n),
  .pwr_on       (pwr_on),
  .ser_clk      (ser_clk),
  .frame_done_w (frame_done_w),
  .frame_seen   (frame_seen),
  .result_valid (result_valid),
  .status       (status),
  .flag_range   (flag_range)
);

// File: tb/tb_bridge_adc_reader.sv
`timescale 1ns/1ps
module tb_bridge_adc_reader;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwr_on = 1'b0;
  logic cfg_gain_one = 1'b1;
  logic cfg_filter_slow = 1'b0;
  logic adc_sdo = 1'b1;
  logic ser_clk;
  logic [19:0] result;
  logic [7:0]  status;
  logic frame_seen, result_valid, flag_link, flag_range, flag_cfg;

  int checks = 0;
  int fails  = 0;
  int seen_cnt = 0;
  int fall_cnt = 0;
  int min_low = 1000000;
  int min_high = 1000000;
  int run_low = 0;
  int run_high = 0;
  bit done_flag = 0;

  typedef struct {
    logic [19:0] res;
    logic [7:0]  st;
    logic link, rng, cfg, vld;
  } exp_t;
  exp_t sb[$];

  always #5 clk = ~clk;

  bridge_adc_reader dut (
    .clk(clk), .rst_n(rst_n), .pwr_on(pwr_on),
    .cfg_gain_one(cfg_gain_one), .cfg_filter_slow(cfg_filter_slow),
    .adc_sdo(adc_sdo), .ser_clk(ser_clk), .result(result), .status(status),
    .frame_seen(frame_seen), .result_valid(result_valid),
    .flag_link(flag_link), .flag_range(flag_range), .flag_cfg(flag_cfg)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] mk_st(input bit rdy, input bit filt, input bit err,
                                       input bit [1:0] id, input bit gain, input bit [1:0] pat);
    return {rdy, filt, err, id, gain, pat};
  endfunction

  // expected item from the requirements, then the converter model sends it
  task automatic send_frame(input logic [19:0] code, input logic [3:0] pad, input logic [7:0] st);
    exp_t e;
    logic [31:0] f;
    e.res  = {~code[19], code[18:0]};
    e.st   = st;
    e.link = (st[1:0] != 2'b01) || (st[4:3] != 2'b00) || st[7] || (pad != 4'd0);
    e.rng  = st[5];
    e.cfg  = (st[2] != cfg_gain_one) || (st[6] != cfg_filter_slow);
    e.vld  = !(e.link || e.rng || e.cfg);
    sb.push_back(e);
    f = {code, pad, st};
    adc_sdo = 1'b0;
    for (int i = 31; i >= 0; i--) begin
      @(negedge ser_clk);
      #1 adc_sdo = f[i];
    end
    @(posedge ser_clk);
    repeat (4) @(posedge clk);
    adc_sdo = 1'b1;
    repeat (8) @(posedge clk);
  endtask

  // monitor: pop and compare on every frame strobe
  always @(negedge clk) begin
    if (rst_n && frame_seen) begin
      exp_t e;
      seen_cnt++;
      if (sb.size() == 0) begin
        chk("R9 unexpected frame", 32'd1, 32'd0);
      end else begin
        e = sb.pop_front();
        chk("R4 result", {12'd0, result}, {12'd0, e.res});
        chk("R5 status", {24'd0, status}, {24'd0, e.st});
        chk("R6 flag_link", {31'd0, flag_link}, {31'd0, e.link});
        chk("R7 flag_range", {31'd0, flag_range}, {31'd0, e.rng});
        chk("R8 flag_cfg", {31'd0, flag_cfg}, {31'd0, e.cfg});
        chk("R9 result_valid", {31'd0, result_valid}, {31'd0, e.vld});
      end
    end
  end

  // serial clock phase lengths and fall count
  always @(negedge clk) begin
    if (rst_n) begin
      if (ser_clk) begin
        if (run_low > 0 && run_low < min_low) min_low = run_low;
        run_low = 0;
        run_high++;
      end else begin
        if (run_high > 0 && run_high < min_high) min_high = run_high;
        run_high = 0;
        run_low++;
      end
    end
  end
  always @(negedge ser_clk) if (rst_n) fall_cnt++;

  initial begin
    repeat (150000) @(posedge clk);
    if (!done_flag) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int seen_before;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk("R2 reset ser_clk high", {31'd0, ser_clk}, 32'd1);
    chk("R9 reset valid low", {31'd0, result_valid}, 32'd0);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);

    // R1: line low while powered down is ignored
    adc_sdo = 1'b0;
    repeat (200) @(posedge clk);
    @(negedge clk);
    chk("R1 no clock while off", fall_cnt, 0);
    chk("R1 no frame while off", seen_cnt, 0);
    adc_sdo = 1'b1;
    repeat (5) @(posedge clk);
    pwr_on = 1'b1;
    repeat (5) @(posedge clk);

    // R3/R4 code corners, gain 1, fast filter
    send_frame(20'h80000, 4'h0, mk_st(0, 0, 0, 2'b00, 1, 2'b01));
    send_frame(20'h00000, 4'h0, mk_st(0, 0, 0, 2'b00, 1, 2'b01));
    send_frame(20'hFFFFF, 4'h0, mk_st(0, 0, 0, 2'b00, 1, 2'b01));
    send_frame(20'h12345, 4'h0, mk_st(0, 0, 0, 2'b00, 1, 2'b01));
    // R6 integrity faults
    send_frame(20'hA5A5A, 4'h0, mk_st(0, 0, 0, 2'b00, 1, 2'b00));
    send_frame(20'h5A5A5, 4'h0, mk_st(0, 0, 0, 2'b00, 1, 2'b10));
    send_frame(20'h0F0F0, 4'h0, mk_st(0, 0, 0, 2'b01, 1, 2'b01));
    send_frame(20'hF0F0F, 4'h0, mk_st(1, 0, 0, 2'b00, 1, 2'b01));
    send_frame(20'h33333, 4'h4, mk_st(0, 0, 0, 2'b00, 1, 2'b01));
    // R7 range error
    send_frame(20'hCCCCC, 4'h0, mk_st(0, 0, 1, 2'b00, 1, 2'b01));
    // R8 echo mismatches, then a match with the other settings
    send_frame(20'h11111, 4'h0, mk_st(0, 0, 0, 2'b00, 0, 2'b01));
    send_frame(20'h22222, 4'h0, mk_st(0, 1, 0, 2'b00, 1, 2'b01));
    cfg_gain_one = 1'b0;
    cfg_filter_slow = 1'b1;
    repeat (3) @(posedge clk);
    send_frame(20'h7FFFF, 4'h0, mk_st(0, 1, 0, 2'b00, 0, 2'b01));

    repeat (5) @(negedge clk);
    chk("R9 one strobe per frame", seen_cnt, 13);
    chk("R2 32 pulses per frame", fall_cnt, 13 * 32);
    chk("R2 min low phase", {31'd0, min_low >= 10}, 32'd1);
    chk("R2 min high phase", {31'd0, min_high >= 10}, 32'd1);
    chk("R9 queue drained", sb.size(), 0);

    // R10 abort mid-frame
    seen_before = seen_cnt;
    adc_sdo = 1'b0;
    repeat (60) @(posedge clk);
    pwr_on = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk("R10 ser_clk parked", {31'd0, ser_clk}, 32'd1);
    repeat (100) @(posedge clk);
    @(negedge clk);
    chk("R10 no frame after abort", seen_cnt, seen_before);
    chk("R10 still parked", {31'd0, ser_clk}, 32'd1);

    done_flag = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule